// File: doc/BRIEF.md
# Tree Reduction and Prefix-Scan Index Sequencer

This block walks through the operation list of a binary-tree reduction or of a work-efficient inclusive prefix scan over a vector of up to 127 elements. It emits one operand index per operation. A separate arithmetic unit reads two elements at the indices given, combines them, and writes the result to the right-hand element. The sequencer itself never touches element data.

A run begins with a start pulse that carries the element count, a 2-bit mode and a level-reversal flag. The block then offers one operation at a time. The operation is held until the consumer raises `step`. The final operation is flagged with `last`, and a one-cycle `done` pulse follows it. One mode bit picks the schedule and the other picks which operand index appears on `idx`. To get both indices of every operation, a consumer runs the same schedule twice, or uses two copies of the block with different mode bit 0.

Top module: `prefix_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, `valid`, `last` and `done` are low.
- R2: `mode[1]` = 0 selects the reduction schedule and `mode[1]` = 1 selects the scan schedule. `mode[0]` = 0 puts the left operand index on `idx` and `mode[0]` = 1 puts the right operand index there.
- R3: The reduction schedule is the up-sweep alone. Stride s takes the values 1, 2, 4, … while s < count. Within a stride, offset j runs 0, 2s, 4s, … while j + s < count. Each operation has left = j + s − 1 and right = min(j + 2s − 1, count − 1).
- R4: The scan schedule is the up-sweep followed by a down-sweep. The down-sweep starts at half the largest up-sweep stride and halves the stride down to 1. At each stride, j runs 0, 2s, 4s, …, with left = j + 2s − 1 and right = left + s. An operation is issued only while right < count − 1. If each operation adds the left element into the right element, every element ends up holding its inclusive prefix.
- R5: With `rev_levels` = 1, the up-sweep strides are visited largest first, in descending order. Operation order within a stride is unchanged, and so is the down-sweep.
- R6: An offered operation stays on `idx` and `last` for as long as `step` is low. One operation retires in each cycle where `valid` and `step` are both high.
- R7: `last` is high exactly while the final operation of the schedule is offered.
- R8: `done` is high for exactly one cycle, in the cycle after the final operation retires. `valid` is low in that cycle.
- R9: For a count of 0 or 1, `done` pulses in the cycle after start and `valid` never rises.
- R10: `start` has no effect while `valid` is high. A `start` in the `done` cycle is accepted, and its first operation is offered in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a schedule (taken only when idle) |
| count | input | 7 | Element count, sampled with start |
| mode | input | 2 | Schedule and operand select, sampled with start |
| rev_levels | input | 1 | Visit up-sweep strides in descending order |
| step | input | 1 | Consumer accepts the offered operation |
| valid | output | 1 | An operation is offered |
| idx | output | 7 | Selected operand index of the offered operation |
| last | output | 1 | The offered operation is the final one |
| done | output | 1 | One-cycle pulse after the schedule ends |

## Verification
Two events can fall in the same cycle. The first pair is retirement of the final up-sweep operation of a stride together with the switch to the next stride or to the down-sweep. The bench provokes this at every stride edge, for counts just above and just below powers of two, with `step` stalled at random, and compares `idx` and `last` on every clock against a behavioural queue. The second pair is the `done` pulse together with a new `start`. The bench chains runs back to back, including runs that follow an empty schedule, and expects the new schedule's first operation in the very next cycle. A further check is that `start` pulses during a run leave the sequence unchanged.

// File: rtl/prefix_sched.sv
module prefix_sched #(
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [IW-1:0] count,
  input  logic [1:0]    mode,
  input  logic          rev_levels,
  input  logic          step,
  output logic          valid,
  output logic [IW-1:0] idx,
  output logic          last,
  output logic          done
);
  localparam int AW = IW + 2;
  localparam int LW = $clog2(IW);

  typedef enum logic [1:0] {S_IDLE, S_UP, S_DN} st_t;

  st_t           st;
  logic [IW-1:0] n_q;
  logic          scan_q, rsel_q, rev_q, done_q;
  logic [LW-1:0] lvl, top_q;
  logic [AW-1:0] j;

  function automatic logic [LW-1:0] top_of(input logic [IW-1:0] nn);
    logic [LW-1:0] r;
    r = '0;
    for (int k = 0; k < IW; k++)
      if ((AW'(1) << k) < AW'(nn)) r = LW'(k);
    return r;
  endfunction

  function automatic logic [LW:0] dn_first(input logic [IW-1:0] nn, input logic [LW-1:0] t);
    logic [LW:0] r;
    r = '0;
    for (int k = 0; k < IW; k++)
      if (LW'(k) < t && (AW'(3) << k) < AW'(nn)) r = {1'b1, LW'(k)};
    return r;
  endfunction

  logic [LW-1:0] top_in;
  logic [LW:0]   dfirst;
  logic [AW-1:0] s, nn, nm1, up_l, up_rr, up_r, dn_l, dn_r, j_nx, cur;
  logic          more_up, more_dn, up_end, go_dn;

  assign top_in  = top_of(count);
  assign dfirst  = dn_first(n_q, top_q);
  assign s       = AW'(1) << lvl;
  assign nn      = AW'(n_q);
  assign nm1     = nn - AW'(1);
  assign up_l    = j + s - AW'(1);
  assign up_rr   = j + (s << 1) - AW'(1);
  assign up_r    = (up_rr > nm1) ? nm1 : up_rr;
  assign dn_l    = j + (s << 1) - AW'(1);
  assign dn_r    = dn_l + s;
  assign j_nx    = j + (s << 1);
  assign more_up = (j_nx + s) < nn;
  assign more_dn = (dn_r + (s << 1)) < nm1;
  assign up_end  = rev_q ? (lvl == '0) : (lvl == top_q);
  assign go_dn   = scan_q && dfirst[LW];

  always_comb begin
    if (st == S_DN) cur = rsel_q ? dn_r : dn_l;
    else            cur = rsel_q ? up_r : up_l;
  end

  assign valid = (st != S_IDLE);
  assign idx   = cur[IW-1:0];
  assign done  = done_q;
  assign last  = (st == S_UP) ? (!more_up && up_end && !go_dn)
               : (st == S_DN) ? (!more_dn && lvl == '0) : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      done_q <= 1'b0;
      n_q    <= '0;
      scan_q <= 1'b0;
      rsel_q <= 1'b0;
      rev_q  <= 1'b0;
      lvl    <= '0;
      top_q  <= '0;
      j      <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          n_q    <= count;
          scan_q <= mode[1];
          rsel_q <= mode[0];
          rev_q  <= rev_levels;
          top_q  <= top_in;
          j      <= '0;
          lvl    <= rev_levels ? top_in : '0;
          if (count < IW'(2)) done_q <= 1'b1;
          else                st     <= S_UP;
        end
        S_UP: if (step) begin
          if (more_up) j <= j_nx;
          else if (!up_end) begin
            lvl <= rev_q ? lvl - LW'(1) : lvl + LW'(1);
            j   <= '0;
          end else if (go_dn) begin
            st  <= S_DN;
            lvl <= dfirst[LW-1:0];
            j   <= '0;
          end else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        S_DN: if (step) begin
          if (more_dn) j <= j_nx;
          else if (lvl != '0) begin
            lvl <= lvl - LW'(1);
            j   <= '0;
          end else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    last |-> valid); // R7
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    valid && !step |=> valid && $stable(idx) && $stable(last)); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    valid && step && last |=> done && !valid); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !valid); // R8
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    valid |-> (idx < n_q) && (cur[AW-1:IW] == '0)); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    valid && start && !(step && last) |=> valid); // R10
  AST_EMPTY_RUN: assert property (@(posedge clk) disable iff (rst)
    !valid && start && count < IW'(2) |=> done && !valid); // R9
endmodule

// File: tb/prefix_sched_test.sv
`timescale 1ns/1ps
module prefix_sched_test;
  logic       clk = 1'b0;
  logic       rst, start, rev_i, step_i;
  logic [6:0] n_i;
  logic [1:0] sm_i;
  logic       valid, last, done;
  logic [6:0] idx;

  always #2 clk = ~clk;

  prefix_sched uut (
    .clk(clk), .rst(rst), .start(start), .count(n_i), .mode(sm_i),
    .rev_levels(rev_i), .step(step_i), .valid(valid), .idx(idx),
    .last(last), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int expq[$];
  int capq[$];
  int capL[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void build(input int nn, input int sm, input bit rv);
    int lv[$];
    int top;
    int l;
    int r;
    expq.delete();
    top = 0;
    for (int s = 1; s < nn; s = s * 2) begin
      lv.push_back(s);
      top = s;
    end
    if (rv) lv.reverse();
    foreach (lv[q]) begin
      for (int jj = 0; jj + lv[q] < nn; jj = jj + 2 * lv[q]) begin
        l = jj + lv[q] - 1;
        r = jj + 2 * lv[q] - 1;
        if (r > nn - 1) r = nn - 1;
        expq.push_back(sm[0] ? r : l);
      end
    end
    if (sm[1]) begin
      for (int s = top / 2; s >= 1; s = s / 2) begin
        for (int jj = 0; jj + 3 * s - 1 < nn - 1; jj = jj + 2 * s) begin
          l = jj + 2 * s - 1;
          expq.push_back(sm[0] ? l + s : l);
        end
      end
    end
  endfunction

  task automatic run(input int nn, input int sm, input bit rv, input int stall,
                     input bit poke, input string tg);
    int k;
    bit st;
    build(nn, sm, rv);
    capq.delete();
    start = 1'b1;
    n_i   = 7'(nn);
    sm_i  = 2'(sm);
    rev_i = rv;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (k < expq.size()) begin
      chk(valid === 1'b1, {tg, " R6 valid"}, int'(valid), 1);
      chk(int'(idx) == expq[k], {tg, " R2 idx"}, int'(idx), expq[k]);
      chk(last == (k == expq.size() - 1), {tg, " R7 last"}, int'(last), int'(k == expq.size() - 1));
      chk(done == 1'b0, {tg, " R8 early done"}, int'(done), 0);
      st = ($urandom_range(99) >= stall);
      step_i = st;
      if (poke) begin
        start = ($urandom_range(3) == 0);
        n_i   = 7'($urandom_range(127));
        sm_i  = 2'($urandom_range(3));
        rev_i = ~rv;
      end
      if (st) begin
        capq.push_back(int'(idx));
        k++;
      end
      @(negedge clk);
    end
    step_i = 1'b0;
    start  = 1'b0;
    chk(done == 1'b1, nn < 2 ? {tg, " R9 done"} : {tg, " R8 done"}, int'(done), 1);
    chk(valid == 1'b0, nn < 2 ? {tg, " R9 valid"} : {tg, " R8 valid"}, int'(valid), 0);
  endtask

  task automatic idle_gap();
    @(negedge clk);
    chk(done == 1'b0, "R8 pulse width", int'(done), 0);
    chk(valid == 1'b0, "R8 idle", int'(valid), 0);
  endtask

  task automatic scan_math(input int nn);
    int v[];
    run(nn, 2, 0, 30, 0, "R4 left");
    capL = capq;
    idle_gap();
    run(nn, 3, 0, 30, 0, "R4 right");
    idle_gap();
    chk(capL.size() == capq.size(), "R4 op count", capL.size(), capq.size());
    v = new[nn];
    for (int i = 0; i < nn; i++) v[i] = i + 1;
    for (int q = 0; q < capq.size() && q < capL.size(); q++) v[capq[q]] += v[capL[q]];
    for (int i = 0; i < nn; i++) chk(v[i] == (i + 1) * (i + 2) / 2, "R4 prefix", v[i], (i + 1) * (i + 2) / 2);
  endtask

  task automatic reduce_math(input int nn);
    int v[];
    run(nn, 0, 0, 20, 0, "R3 left");
    capL = capq;
    idle_gap();
    run(nn, 1, 0, 20, 0, "R3 right");
    idle_gap();
    v = new[nn];
    for (int i = 0; i < nn; i++) v[i] = i + 1;
    for (int q = 0; q < capq.size() && q < capL.size(); q++) v[capq[q]] += v[capL[q]];
    chk(v[nn - 1] == nn * (nn + 1) / 2, "R3 total", v[nn - 1], nn * (nn + 1) / 2);
  endtask

  initial begin
    int ns[$];
    ns = '{0, 1, 2, 3, 4, 5, 7, 8, 9, 16, 17, 31, 33, 64, 100, 127};
    rst = 1'b1; start = 1'b0; step_i = 1'b0; n_i = '0; sm_i = '0; rev_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R1 valid", int'(valid), 0);
    chk(last == 1'b0, "R1 last", int'(last), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(valid == 1'b0 && done == 1'b0, "R1 after reset", int'(valid | done), 0);
    foreach (ns[a]) begin
      for (int sm = 0; sm < 4; sm++) begin
        for (int rv = 0; rv < 2; rv++) begin
          run(ns[a], sm, rv[0], 25, (ns[a] % 3 == 0),
              rv != 0 ? "R5 rev" : ((ns[a] % 3 == 0) ? "R10 poke" : (sm > 1 ? "R4 scan" : "R3 reduce")));
          idle_gap();
        end
      end
    end
    run(9, 2, 0, 0, 0, "R10 first");
    run(12, 1, 1, 0, 0, "R10 chained");
    run(1, 0, 0, 0, 0, "R9 empty");
    run(5, 3, 0, 0, 0, "R10 after empty");
    run(0, 2, 1, 0, 0, "R9 zero");
    idle_gap();
    foreach (ns[a]) if (ns[a] >= 2) begin
      scan_math(ns[a]);
      reduce_math(ns[a]);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule